// File: doc/BRIEF.md
# Video Clamp Pulse Timing Generator

This block sits in the pixel clock domain of an analog video digitizer front end. It produces three signals. The first is a one-clock leading-edge strobe that gives the clock generator its line timing reference. The second is a qualified coast signal that tells the clock generator to stop following sync. The third is the per-line clamp pulse that drives the input clamp switches. The raw horizontal sync, the external clamp input and the coast input each pass through a two-flop synchronizer. Each is then normalized against its own polarity bit, so the rest of the logic only sees "active" and "inactive".

In internal mode the clamp window is timed from the sync trailing edge. The pulse starts a programmed number of pixel clocks after that edge and lasts a programmed number of clocks. In external mode the internal timer is bypassed, and the clamp pulse follows the synchronized external clamp input, interpreted through its own polarity bit. The delay and width values are captured at each trailing edge. A register write made during a line therefore only changes the next line's pulse.

Top module: `clamp_timing_gen`

## Requirements
- R1: While reset is asserted and the inputs are idle, `clamp_out` and `lead_strobe` are 0, and `coast_act` is 0 when the coast input is 0 and `cfg_coast_pol` is 1.
- R2: When `cfg_hs_pol` is 1, a rising raw sync edge is the leading edge and a falling one is the trailing edge. When it is 0, the falling raw edge is the leading edge and the rising one is the trailing edge.
- R3: `lead_strobe` is high for exactly one clock per leading edge. It is high in the third clock after the raw sync changes (counting the first rising clock edge that samples the new level as clock 1), and it never follows a trailing edge.
- R4: `coast_act` is 1 when the synchronized coast input equals `cfg_coast_pol`. This appears two clocks after the raw input changes, or at once when the polarity bit changes. A leading edge seen while `coast_act` is 1 produces no strobe.
- R5: With `cfg_ext_clamp_en` at 0, a trailing edge applied to the raw sync after clock 0 makes `clamp_out` high from clock 3+D through clock 2+D+W and low otherwise. D is `cfg_clamp_delay` and W is `cfg_clamp_width`, both counted in pixel clocks.
- R6: A width of 0 produces no clamp pulse at all.
- R7: A trailing edge that arrives while a delay or width count is running ends the current pulse and restarts the delay count for a new full pulse.
- R8: Delay and width are captured at the trailing edge. Changing them in the middle of a pulse does not alter that pulse, and the new values shape the next pulse.
- R9: With `cfg_ext_clamp_en` at 1, `clamp_out` is 1 exactly when the synchronized external clamp input equals `cfg_clamp_pol` (two clocks after a raw change). Internal sync timing does not reach the output.
- R10: With `cfg_ext_clamp_en` at 0, the external clamp input has no effect on `clamp_out`.
- R11: A leading edge never starts a clamp pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_raw | input | 1 | Unsynchronized horizontal sync |
| ext_clamp_raw | input | 1 | Unsynchronized external clamp window |
| coast_raw | input | 1 | Unsynchronized coast request |
| cfg_hs_pol | input | 1 | 1: rising sync edge leads; 0: falling edge leads |
| cfg_ext_clamp_en | input | 1 | 1: clamp follows external input; 0: internal timer (reset value 0 at the register) |
| cfg_clamp_pol | input | 1 | Level of the external clamp input that means active |
| cfg_coast_pol | input | 1 | Level of the coast input that means active (reset value 1 at the register) |
| cfg_clamp_delay | input | 8 | Clocks from trailing edge to clamp start |
| cfg_clamp_width | input | 8 | Clamp pulse length in clocks; 0 disables |
| lead_strobe | output | 1 | One-clock leading-edge strobe to the clock generator |
| coast_act | output | 1 | Qualified, active-high coast |
| clamp_out | output | 1 | Active-high clamp pulse |

## Verification
The bench aims at the cycle boundaries of the clamp window. It uses zero delay, a one-clock width and a long delay, and a design that is off by one in either counter would shift or stretch the pulse by a clock. It retriggers a running pulse and rewrites the registers while a pulse is running. A design that ignored the restart would keep the old pulse alive, and one that read the registers live would cut a pulse short. Both sync polarities are exercised, so a design that timed the clamp from the wrong edge or strobed on the trailing edge would show a pulse or strobe in the wrong place. Coast and the external clamp path are each flipped through both polarities, and the external input is toggled while disabled, so any leak into the outputs is caught.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  typedef enum logic [1:0] {
    CL_IDLE   = 2'd0,
    CL_DELAY  = 2'd1,
    CL_ACTIVE = 2'd2
  } clamp_state_e;

  // index of each synchronized input inside the shared synchronizer array
  localparam int unsigned IDX_HS    = 0;
  localparam int unsigned IDX_EXT   = 1;
  localparam int unsigned IDX_COAST = 2;
  localparam int unsigned N_INPUTS  = 3;

  // an input is "active" when its level matches its polarity bit
  function automatic logic level_active(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction

  // value loaded into a down counter that must run for n clocks (n >= 1)
  function automatic logic [7:0] span_load(input logic [7:0] n);
    return n - 8'd1;
  endfunction

endpackage

// File: rtl/cpt_sync_norm.sv
module cpt_sync_norm #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic pol,
  output logic act
);
  import clamp_pkg::*;

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= raw_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], raw_in};
      end
    end
  endgenerate

  assign act = level_active(chain[STAGES-1], pol);

endmodule

// File: rtl/cpt_clamp_timer.sv
module cpt_clamp_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trail_evt,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic [CNT_W-1:0] cfg_width,
  output logic             pulse_on,
  output logic             busy
);
  import clamp_pkg::*;

  clamp_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] w_lat;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CL_IDLE;
      cnt   <= '0;
      w_lat <= '0;
    end else if (trail_evt) begin
      // every trailing edge restarts the window with fresh register values
      w_lat <= cfg_width;
      if (cfg_width == '0) begin
        state <= CL_IDLE;
        cnt   <= '0;
      end else if (cfg_delay == '0) begin
        state <= CL_ACTIVE;
        cnt   <= span_load(cfg_width);
      end else begin
        state <= CL_DELAY;
        cnt   <= span_load(cfg_delay);
      end
    end else begin
      unique case (state)
        CL_DELAY: begin
          if (cnt_zero) begin
            state <= CL_ACTIVE;
            cnt   <= span_load(w_lat);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CL_ACTIVE: begin
          if (cnt_zero) state <= CL_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: begin
          state <= CL_IDLE;
        end
      endcase
    end
  end

  assign pulse_on = (state == CL_ACTIVE);
  assign busy     = (state != CL_IDLE);

  p_zero_width_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (trail_evt && cfg_width == '0) |=> (state == CL_IDLE));

  p_active_holds_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (state == CL_ACTIVE && !cnt_zero && !trail_evt) |=> (state == CL_ACTIVE));

  p_restart_delay_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (trail_evt && cfg_width != '0 && cfg_delay != '0) |=> (state == CL_DELAY));

  p_width_latched_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !trail_evt |=> $stable(w_lat));

endmodule

// File: rtl/clamp_timing_gen.sv
module clamp_timing_gen #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_raw,
  input  logic             ext_clamp_raw,
  input  logic             coast_raw,
  input  logic             cfg_hs_pol,
  input  logic             cfg_ext_clamp_en,
  input  logic             cfg_clamp_pol,
  input  logic             cfg_coast_pol,
  input  logic [CNT_W-1:0] cfg_clamp_delay,
  input  logic [CNT_W-1:0] cfg_clamp_width,
  output logic             lead_strobe,
  output logic             coast_act,
  output logic             clamp_out
);
  import clamp_pkg::*;

  logic [N_INPUTS-1:0] raw_vec;
  logic [N_INPUTS-1:0] pol_vec;
  logic [N_INPUTS-1:0] act_vec;

  assign raw_vec[IDX_HS]    = hsync_raw;
  assign raw_vec[IDX_EXT]   = ext_clamp_raw;
  assign raw_vec[IDX_COAST] = coast_raw;
  assign pol_vec[IDX_HS]    = cfg_hs_pol;
  assign pol_vec[IDX_EXT]   = cfg_clamp_pol;
  assign pol_vec[IDX_COAST] = cfg_coast_pol;

  generate
    for (genvar k = 0; k < N_INPUTS; k++) begin : g_in
      cpt_sync_norm #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (raw_vec[k]),
        .pol    (pol_vec[k]),
        .act    (act_vec[k])
      );
    end
  endgenerate

  // previous synchronized sync level, normalized with the current polarity
  logic hs_prev_lvl;
  logic hs_now_act;
  logic hs_prev_act;
  logic lead_evt;
  logic trail_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_prev_lvl <= 1'b0;
    else        hs_prev_lvl <= (act_vec[IDX_HS] == cfg_hs_pol);
  end

  assign hs_now_act  = act_vec[IDX_HS];
  assign hs_prev_act = level_active(hs_prev_lvl, cfg_hs_pol);
  assign lead_evt    = hs_now_act && !hs_prev_act;
  assign trail_evt   = !hs_now_act && hs_prev_act;

  assign coast_act = act_vec[IDX_COAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lead_strobe <= 1'b0;
    else        lead_strobe <= lead_evt && !coast_act;
  end

  logic timer_pulse;
  logic timer_busy;

  cpt_clamp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .trail_evt (trail_evt),
    .cfg_delay (cfg_clamp_delay),
    .cfg_width (cfg_clamp_width),
    .pulse_on  (timer_pulse),
    .busy      (timer_busy)
  );

  assign clamp_out = cfg_ext_clamp_en ? act_vec[IDX_EXT] : timer_pulse;

  p_strobe_single_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    lead_strobe |=> !lead_strobe);

  p_coast_blocks_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    coast_act |=> !lead_strobe);

  p_lead_no_clamp_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (lead_evt && !timer_busy) |=> !timer_busy);

  p_trail_no_strobe_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    trail_evt |=> !lead_strobe);

endmodule

// File: tb/tb_clamp_timing_gen.sv
`timescale 1ns/1ps
module tb_clamp_timing_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_raw = 1'b0;
  logic       ext_clamp_raw = 1'b0;
  logic       coast_raw = 1'b0;
  logic       cfg_hs_pol = 1'b1;
  logic       cfg_ext_clamp_en = 1'b0;
  logic       cfg_clamp_pol = 1'b1;
  logic       cfg_coast_pol = 1'b1;
  logic [7:0] cfg_clamp_delay = 8'd2;
  logic [7:0] cfg_clamp_width = 8'd3;
  logic       lead_strobe;
  logic       coast_act;
  logic       clamp_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clamp_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .hsync_raw(hsync_raw), .ext_clamp_raw(ext_clamp_raw),
    .coast_raw(coast_raw), .cfg_hs_pol(cfg_hs_pol), .cfg_ext_clamp_en(cfg_ext_clamp_en),
    .cfg_clamp_pol(cfg_clamp_pol), .cfg_coast_pol(cfg_coast_pol),
    .cfg_clamp_delay(cfg_clamp_delay), .cfg_clamp_width(cfg_clamp_width),
    .lead_strobe(lead_strobe), .coast_act(coast_act), .clamp_out(clamp_out)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // advance one clock and land on the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  // expected clamp level i clocks after a trailing edge driven at clock base
  function automatic logic in_win(input int i, input int base, input int d, input int w);
    return (i - base) >= 3 + d && (i - base) < 3 + d + w;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    idle(3);
    chk("R1", "clamp_out in reset", clamp_out, 1'b0);
    chk("R1", "lead_strobe in reset", lead_strobe, 1'b0);
    chk("R1", "coast_act in reset", coast_act, 1'b0);
    rst_n = 1'b1;
    idle(4);
    chk("R1", "clamp_out after reset", clamp_out, 1'b0);
  endtask

  task automatic t_polarity();
    cfg_clamp_delay = 8'd1;
    cfg_clamp_width = 8'd2;
    cfg_hs_pol = 1'b1;
    hsync_raw = 1'b1;                    // rising = leading
    for (int i = 1; i <= 8; i++) begin
      step();
      chk("R2", "rising strobe pol1", lead_strobe, i == 3);
      chk("R11", "no clamp after leading", clamp_out, 1'b0);
    end
    hsync_raw = 1'b0;                    // falling = trailing
    for (int i = 1; i <= 8; i++) begin
      step();
      chk("R3", "no strobe on trailing pol1", lead_strobe, 1'b0);
      chk("R2", "clamp after falling pol1", clamp_out, in_win(i, 0, 1, 2));
    end
    idle(4);
    cfg_hs_pol = 1'b0;                   // low level now active, no edge
    step();
    chk("R2", "no strobe on polarity change", lead_strobe, 1'b0);
    hsync_raw = 1'b1;                    // rising = trailing
    for (int i = 1; i <= 8; i++) begin
      step();
      chk("R3", "no strobe on rising pol0", lead_strobe, 1'b0);
      chk("R2", "clamp after rising pol0", clamp_out, in_win(i, 0, 1, 2));
    end
    idle(4);
    hsync_raw = 1'b0;                    // falling = leading
    for (int i = 1; i <= 8; i++) begin
      step();
      chk("R2", "falling strobe pol0", lead_strobe, i == 3);
      chk("R11", "no clamp after falling pol0", clamp_out, 1'b0);
    end
    cfg_hs_pol = 1'b1;                   // level 0 now inactive, no edge
    idle(10);
    chk("R2", "quiet after restoring polarity", clamp_out, 1'b0);
  endtask

  task automatic t_coast();
    coast_raw = 1'b1;
    step();
    chk("R4", "coast not yet through synchronizer", coast_act, 1'b0);
    step();
    chk("R4", "coast active two clocks later", coast_act, 1'b1);
    hsync_raw = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      step();
      chk("R4", "strobe blocked in coast", lead_strobe, 1'b0);
    end
    hsync_raw = 1'b0;
    idle(10);
    cfg_coast_pol = 1'b0;
    #1;
    chk("R4", "coast inactive after polarity flip", coast_act, 1'b0);
    @(negedge clk);
    hsync_raw = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      step();
      chk("R3", "strobe once without coast", lead_strobe, i == 3);
    end
    hsync_raw = 1'b0;
    idle(10);
    coast_raw = 1'b0;
    idle(2);
    chk("R4", "low coast active with pol 0", coast_act, 1'b1);
    cfg_coast_pol = 1'b1;
    #1;
    chk("R4", "coast inactive restored", coast_act, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_internal(input int d, input int w);
    cfg_clamp_delay = 8'(d);
    cfg_clamp_width = 8'(w);
    hsync_raw = 1'b1;
    idle(8);
    hsync_raw = 1'b0;
    for (int i = 1; i <= d + w + 6; i++) begin
      step();
      chk("R5", $sformatf("clamp d=%0d w=%0d i=%0d", d, w, i), clamp_out, in_win(i, 0, d, w));
    end
  endtask

  task automatic t_zero_width();
    cfg_clamp_delay = 8'd3;
    cfg_clamp_width = 8'd0;
    hsync_raw = 1'b1;
    idle(8);
    hsync_raw = 1'b0;
    for (int i = 1; i <= 15; i++) begin
      step();
      chk("R6", "no pulse for width 0", clamp_out, 1'b0);
    end
  endtask

  task automatic t_retrigger();
    cfg_clamp_delay = 8'd4;
    cfg_clamp_width = 8'd6;
    hsync_raw = 1'b1;
    idle(8);
    hsync_raw = 1'b0;
    for (int i = 1; i <= 26; i++) begin
      step();
      chk("R7", $sformatf("retrigger i=%0d", i), clamp_out,
          (i < 11) ? in_win(i, 0, 4, 6) : in_win(i, 8, 4, 6));
      if (i == 6) hsync_raw = 1'b1;
      if (i == 8) hsync_raw = 1'b0;
    end
  endtask

  task automatic t_reg_change();
    cfg_clamp_delay = 8'd2;
    cfg_clamp_width = 8'd5;
    hsync_raw = 1'b1;
    idle(8);
    hsync_raw = 1'b0;
    for (int i = 1; i <= 24; i++) begin
      step();
      chk("R8", $sformatf("register change i=%0d", i), clamp_out,
          (i < 17) ? in_win(i, 0, 2, 5) : in_win(i, 14, 1, 2));
      if (i == 6) begin
        cfg_clamp_delay = 8'd1;
        cfg_clamp_width = 8'd2;
      end
      if (i == 12) hsync_raw = 1'b1;
      if (i == 14) hsync_raw = 1'b0;
    end
  endtask

  task automatic t_external();
    cfg_clamp_delay = 8'd1;
    cfg_clamp_width = 8'd3;
    cfg_clamp_pol = 1'b1;
    ext_clamp_raw = 1'b0;
    cfg_ext_clamp_en = 1'b1;
    idle(3);
    chk("R9", "ext low inactive", clamp_out, 1'b0);
    hsync_raw = 1'b1;
    idle(6);
    hsync_raw = 1'b0;                    // internal pulse must not appear
    for (int i = 1; i <= 8; i++) begin
      step();
      chk("R9", "internal timing hidden", clamp_out, 1'b0);
    end
    ext_clamp_raw = 1'b1;
    step();
    chk("R9", "ext latency clock 1", clamp_out, 1'b0);
    step();
    chk("R9", "ext high active clock 2", clamp_out, 1'b1);
    cfg_clamp_pol = 1'b0;
    #1;
    chk("R9", "ext high inactive pol 0", clamp_out, 1'b0);
    @(negedge clk);
    ext_clamp_raw = 1'b0;
    idle(2);
    chk("R9", "ext low active pol 0", clamp_out, 1'b1);
    cfg_clamp_pol = 1'b1;
    cfg_ext_clamp_en = 1'b0;
    idle(4);
  endtask

  task automatic t_ext_ignored();
    cfg_clamp_delay = 8'd2;
    cfg_clamp_width = 8'd3;
    for (int i = 1; i <= 8; i++) begin
      ext_clamp_raw = i[0];
      step();
      chk("R10", "ext toggles ignored", clamp_out, 1'b0);
    end
    hsync_raw = 1'b1;
    idle(6);
    hsync_raw = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      step();
      chk("R10", "internal pulse unaffected", clamp_out, in_win(i, 0, 2, 3));
      ext_clamp_raw = ~ext_clamp_raw;
    end
    ext_clamp_raw = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_polarity();
    t_coast();
    t_internal(1, 4);
    t_internal(0, 1);
    t_internal(9, 2);
    t_internal(0, 3);
    t_zero_width();
    t_retrigger();
    t_reg_change();
    t_external();
    t_ext_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule